// File: doc/BRIEF.md
# Spare Row and Column Repair Analyzer

This block works beside a memory self-test engine and decides how the spare rows and spare columns of a repairable RAM should be used. A self-test run opens with a start strobe. During the run, each comparator mismatch arrives as a strobe that carries the failing row and column. The block classifies every mismatch as it arrives:

- A mismatch that a spare already covers is dropped.
- A repeat of a failure already recorded is dropped.
- A mismatch that makes a row or a column impossible to fix any other way takes a spare at once.
- Any other mismatch is held in a small table of pending failures.

When the self-test reports its end, the analyzer walks the pending table and assigns the remaining spares. It then packs the result into a repair signature and sends it out one bit per cycle to a downstream fuse controller.

The results stay on the outputs until the next start: the replacement addresses and their enables, and a repairable flag. A clean run leaves every enable low and reports the memory as repairable.

Top module: `repair_analyzer`

## Requirements
- R1: After reset, and after any accepted `bist_start`, every spare enable is low, every spare address is zero, `repairable` is 1, and the pending table is empty. `bist_start` is accepted only when the block is idle or done, and it enters the collection phase.
- R2: During collection, a failure whose row equals an enabled spare row address, or whose column equals an enabled spare column address, changes no output.
- R3: When a failure arrives in a row already pending with a different column, the lowest free spare row takes that row address. The row's enable is visible on the cycle after the strobe. Pending entries in that row are removed.
- R4: When a failure arrives in a column already pending with a different row, the lowest free spare column takes that column address. The column's enable is visible on the cycle after the strobe. Pending entries in that column are removed.
- R5: A failure that needs a spare that is not free sets `repairable` to 0 on the next cycle. This covers two cases: a forced row or column repair with none of that kind left, and a new independent failure when the pending count already equals the number of free spares. The flag stays 0 until the next accepted start.
- R6: Independent failures do not take spares during collection. After `bist_done`, the pending entries are taken in table order, and each one gets a free spare row (its row address) if any are left, otherwise a free spare column (its column address).
- R7: `fail_valid` outside the collection phase has no effect on any output.
- R8: After analysis the signature {cae, cra, rae, rra} (rra in the least significant bits) is shifted out LSB first on `sig_bit`. `sig_valid` is high for exactly NR*ROW_W+NR+NC*COL_W+NC consecutive cycles, which is 12 with the defaults.
- R9: `analysis_done` rises on the cycle after the last signature bit. It stays high, with `sig_valid` low, until the next accepted start.
- R10: A run with no failures reports `repairable` 1, all enables low and an all-zero signature.
- R11: A failure with the same row and column as a pending entry is dropped. It forces no repair and takes no table slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_start | input | 1 | Self-test run begins; clears all results |
| bist_done | input | 1 | Self-test run finished; analysis starts |
| fail_valid | input | 1 | Comparator mismatch strobe |
| fail_row | input | ROW_W | Row address of the mismatch |
| fail_col | input | COL_W | Column address of the mismatch |
| rra | output | NR*ROW_W | Replacement row addresses, spare k at bits [k*ROW_W +: ROW_W] |
| rae | output | NR | Spare row enables |
| cra | output | NC*COL_W | Replacement column addresses |
| cae | output | NC | Spare column enables |
| repairable | output | 1 | 1 while every recorded failure can still be covered |
| analysis_done | output | 1 | Analysis and signature shift finished |
| sig_bit | output | 1 | Serial repair signature, LSB first |
| sig_valid | output | 1 | Qualifies `sig_bit` |

## Verification
The assertions take the following for granted:
- The pending table has at least NR+NC slots, so that an insertion never meets a full table.
- `fail_row` and `fail_col` are valid whenever `fail_valid` is high.
- `bist_start` and `bist_done` are single-cycle strobes.

The bench keeps to these limits. It drives every strobe for exactly one cycle on the falling edge. It issues `bist_start` only from the idle or done state, and sends mismatch strobes outside collection only to check that they are ignored. It uses the default geometry of one spare of each kind and a four-entry table.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_ANALYZE,
    ST_LOAD,
    ST_SHIFT,
    ST_DONE
  } rpr_state_e;

  // population count of a (zero-extended) 16-bit vector
  function automatic logic [4:0] count_set(input logic [15:0] v);
    logic [4:0] n;
    n = '0;
    for (int i = 0; i < 16; i++) n = n + 5'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/rpr_spare_bank.sv
module rpr_spare_bank #(
  parameter int NUM    = 1,
  parameter int ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  alloc_en,
  input  logic [ADDR_W-1:0]     alloc_addr,
  input  logic [ADDR_W-1:0]     probe_addr,
  output logic                  probe_hit,
  output logic [4:0]            free_cnt,
  output logic [NUM-1:0]        en_vec,
  output logic [NUM*ADDR_W-1:0] addr_vec
);
  import rpr_pkg::*;

  localparam int SLOT_W = (NUM > 1) ? $clog2(NUM) : 1;

  logic [NUM-1:0]        en_q;
  logic [NUM*ADDR_W-1:0] addr_q;
  logic [NUM-1:0]        slot_match;
  logic                  free_found;
  logic [SLOT_W-1:0]     free_slot;

  for (genvar g = 0; g < NUM; g++) begin : g_match
    assign slot_match[g] = en_q[g] && (addr_q[g*ADDR_W +: ADDR_W] == probe_addr);
  end

  // lowest-index free spare
  always_comb begin
    free_found = 1'b0;
    free_slot  = '0;
    for (int k = NUM - 1; k >= 0; k--) begin
      if (!en_q[k]) begin
        free_found = 1'b1;
        free_slot  = SLOT_W'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      addr_q <= '0;
    end else if (clear) begin
      en_q   <= '0;
      addr_q <= '0;
    end else if (alloc_en && free_found) begin
      en_q[free_slot]                        <= 1'b1;
      addr_q[free_slot*ADDR_W +: ADDR_W]     <= alloc_addr;
    end
  end

  assign probe_hit = |slot_match;
  assign free_cnt  = 5'(NUM) - count_set(16'(en_q));
  assign en_vec    = en_q;
  assign addr_vec  = addr_q;

  // R3/R4: a granted spare is never withdrawn within a run
  p_spare_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((en_q & $past(en_q)) == $past(en_q)));

  // R5: the controller only requests a spare when one is free
  p_alloc_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (free_cnt != 5'd0));

endmodule

// File: rtl/rpr_fail_table.sv
module rpr_fail_table #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 6,
  parameter int COL_W = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [ROW_W-1:0] q_row,
  input  logic [COL_W-1:0] q_col,
  output logic             hit_same,
  output logic             hit_row,
  output logic             hit_col,
  input  logic             ins_en,
  input  logic             kill_row_en,
  input  logic             kill_col_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_kill,
  output logic             rd_valid,
  output logic [ROW_W-1:0] rd_row,
  output logic [COL_W-1:0] rd_col,
  output logic [4:0]       used_cnt
);
  import rpr_pkg::*;

  logic [DEPTH-1:0] vld_q;
  logic [ROW_W-1:0] row_q [DEPTH];
  logic [COL_W-1:0] col_q [DEPTH];
  logic [DEPTH-1:0] row_eq, col_eq, drop;
  logic             has_room;
  logic [IDX_W-1:0] ins_slot;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign row_eq[g] = vld_q[g] && (row_q[g] == q_row);
    assign col_eq[g] = vld_q[g] && (col_q[g] == q_col);
    assign drop[g]   = (kill_row_en && row_eq[g]) || (kill_col_en && col_eq[g]) ||
                       (rd_kill && (rd_idx == IDX_W'(g)));
  end

  always_comb begin
    has_room = 1'b0;
    ins_slot = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (!vld_q[k]) begin
        has_room = 1'b1;
        ins_slot = IDX_W'(k);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        row_q[k] <= '0;
        col_q[k] <= '0;
      end
    end else if (clear) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_q & ~drop;
      if (ins_en && has_room) begin
        vld_q[ins_slot] <= 1'b1;
        row_q[ins_slot] <= q_row;
        col_q[ins_slot] <= q_col;
      end
    end
  end

  assign hit_same = |(row_eq & col_eq);
  assign hit_row  = |row_eq;
  assign hit_col  = |col_eq;
  assign rd_valid = vld_q[rd_idx];
  assign rd_row   = row_q[rd_idx];
  assign rd_col   = col_q[rd_idx];
  assign used_cnt = count_set(16'(vld_q));

  // R6: an insertion never meets a full table
  p_insert_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> has_room);

  // R11: an entry that shares a row or column is never inserted beside it
  p_no_dup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !(hit_row || hit_col));

endmodule

// File: rtl/rpr_sig_chain.sv
module rpr_sig_chain #(
  parameter int W = 12,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         ser_bit,
  output logic         ser_valid,
  output logic         ser_last
);
  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load) begin
      sh_q   <= load_data;
      left_q <= CNT_W'(W);
    end else if (left_q != '0) begin
      sh_q   <= sh_q >> 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign ser_bit   = sh_q[0];
  assign ser_valid = (left_q != '0);
  assign ser_last  = (left_q == CNT_W'(1));

  // R8: the strobe only ends after the final bit
  p_shift_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_valid) |-> $past(ser_last));

  // R8: a load always opens a full-length window
  p_load_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ser_valid && left_q == CNT_W'(W)));

endmodule

// File: rtl/repair_analyzer.sv
module repair_analyzer #(
  parameter int ROW_W = 6,
  parameter int COL_W = 4,
  parameter int NR    = 1,
  parameter int NC    = 1,
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SIG_W = NR * ROW_W + NR + NC * COL_W + NC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bist_start,
  input  logic                bist_done,
  input  logic                fail_valid,
  input  logic [ROW_W-1:0]    fail_row,
  input  logic [COL_W-1:0]    fail_col,
  output logic [NR*ROW_W-1:0] rra,
  output logic [NR-1:0]       rae,
  output logic [NC*COL_W-1:0] cra,
  output logic [NC-1:0]       cae,
  output logic                repairable,
  output logic                analysis_done,
  output logic                sig_bit,
  output logic                sig_valid
);
  import rpr_pkg::*;

  rpr_state_e       state_q;
  logic [IDX_W-1:0] scan_q;
  logic             unrep_q;

  // named internal events
  logic clear, fail_take, covered, set_unrep, sig_load, ser_last;
  logic row_hit, col_hit, hit_same, hit_row, hit_col;
  logic row_alloc, col_alloc, tbl_ins, kill_row, kill_col, rd_kill;
  logic [ROW_W-1:0] row_alloc_addr, rd_row;
  logic [COL_W-1:0] col_alloc_addr, rd_col;
  logic             rd_valid;
  logic [4:0]       row_free, col_free, used_cnt;
  logic [5:0]       spare_free;

  assign clear     = bist_start && (state_q == ST_IDLE || state_q == ST_DONE);
  assign fail_take = fail_valid && (state_q == ST_COLLECT);
  assign covered   = row_hit || col_hit;
  assign spare_free = 6'(row_free) + 6'(col_free);
  assign sig_load  = (state_q == ST_LOAD);

  // allocation decisions: must-repair during collection, leftovers in analysis
  always_comb begin
    row_alloc      = 1'b0;
    col_alloc      = 1'b0;
    row_alloc_addr = fail_row;
    col_alloc_addr = fail_col;
    tbl_ins        = 1'b0;
    kill_row       = 1'b0;
    kill_col       = 1'b0;
    rd_kill        = 1'b0;
    set_unrep      = 1'b0;
    if (fail_take && !covered && !hit_same) begin
      if (hit_row) begin
        if (row_free != 5'd0) begin
          row_alloc = 1'b1;
          kill_row  = 1'b1;
        end else begin
          set_unrep = 1'b1;
        end
      end else if (hit_col) begin
        if (col_free != 5'd0) begin
          col_alloc = 1'b1;
          kill_col  = 1'b1;
        end else begin
          set_unrep = 1'b1;
        end
      end else if (6'(used_cnt) < spare_free) begin
        tbl_ins = 1'b1;
      end else begin
        set_unrep = 1'b1;
      end
    end else if (state_q == ST_ANALYZE && rd_valid) begin
      rd_kill = 1'b1;
      if (row_free != 5'd0) begin
        row_alloc      = 1'b1;
        row_alloc_addr = rd_row;
      end else if (col_free != 5'd0) begin
        col_alloc      = 1'b1;
        col_alloc_addr = rd_col;
      end else begin
        set_unrep = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scan_q  <= '0;
      unrep_q <= 1'b0;
    end else begin
      if (clear)          unrep_q <= 1'b0;
      else if (set_unrep) unrep_q <= 1'b1;

      if (state_q == ST_ANALYZE) scan_q <= scan_q + 1'b1;
      else                       scan_q <= '0;

      case (state_q)
        ST_IDLE, ST_DONE: if (bist_start) state_q <= ST_COLLECT;
        ST_COLLECT:       if (bist_done)  state_q <= ST_ANALYZE;
        ST_ANALYZE:       if (scan_q == IDX_W'(DEPTH - 1)) state_q <= ST_LOAD;
        ST_LOAD:          state_q <= ST_SHIFT;
        ST_SHIFT:         if (ser_last) state_q <= ST_DONE;
        default:          state_q <= ST_IDLE;
      endcase
    end
  end

  rpr_spare_bank #(.NUM(NR), .ADDR_W(ROW_W)) u_rows (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .alloc_en(row_alloc), .alloc_addr(row_alloc_addr),
    .probe_addr(fail_row), .probe_hit(row_hit),
    .free_cnt(row_free), .en_vec(rae), .addr_vec(rra)
  );

  rpr_spare_bank #(.NUM(NC), .ADDR_W(COL_W)) u_cols (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .alloc_en(col_alloc), .alloc_addr(col_alloc_addr),
    .probe_addr(fail_col), .probe_hit(col_hit),
    .free_cnt(col_free), .en_vec(cae), .addr_vec(cra)
  );

  rpr_fail_table #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_table (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .q_row(fail_row), .q_col(fail_col),
    .hit_same(hit_same), .hit_row(hit_row), .hit_col(hit_col),
    .ins_en(tbl_ins), .kill_row_en(kill_row), .kill_col_en(kill_col),
    .rd_idx(scan_q), .rd_kill(rd_kill),
    .rd_valid(rd_valid), .rd_row(rd_row), .rd_col(rd_col),
    .used_cnt(used_cnt)
  );

  rpr_sig_chain #(.W(SIG_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .load(sig_load),
    .load_data({cae, cra, rae, rra}),
    .ser_bit(sig_bit), .ser_valid(sig_valid), .ser_last(ser_last)
  );

  assign repairable    = !unrep_q;
  assign analysis_done = (state_q == ST_DONE);

  // R5: unrepairable is sticky until a new run
  p_unrep_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (unrep_q && !clear) |=> unrep_q);

  // R7: mismatch strobes outside collection leave results untouched
  p_ignore_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_valid && !bist_start && (state_q == ST_IDLE || state_q == ST_DONE)) |=>
      ($stable(rae) && $stable(cae) && $stable(rra) && $stable(cra) && $stable(unrep_q)));

  // R2: a covered failure changes nothing
  p_covered_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_take && covered) |=> ($stable(rae) && $stable(cae) && $stable(unrep_q)));

  // R6: pending failures never outnumber the free spares
  p_table_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COLLECT) |-> (6'(used_cnt) <= spare_free));

  // R9: once done, the serial port is quiet
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    analysis_done |-> !sig_valid);

endmodule

// File: tb/repair_analyzer_test.sv
module repair_analyzer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SIG_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bist_start = 1'b0, bist_done = 1'b0, fail_valid = 1'b0;
  logic [5:0] fail_row = '0;
  logic [3:0] fail_col = '0;
  logic [5:0] rra;
  logic [0:0] rae, cae;
  logic [3:0] cra;
  logic repairable, analysis_done, sig_bit, sig_valid;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  repair_analyzer uut (
    .clk(clk), .rst_n(rst_n), .bist_start(bist_start), .bist_done(bist_done),
    .fail_valid(fail_valid), .fail_row(fail_row), .fail_col(fail_col),
    .rra(rra), .rae(rae), .cra(cra), .cae(cae), .repairable(repairable),
    .analysis_done(analysis_done), .sig_bit(sig_bit), .sig_valid(sig_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); bist_start = 1'b1;
    @(negedge clk); bist_start = 1'b0;
  endtask

  task automatic send_fail(input logic [5:0] r, input logic [3:0] c);
    @(negedge clk); fail_valid = 1'b1; fail_row = r; fail_col = c;
    @(negedge clk); fail_valid = 1'b0;
  endtask

  task automatic check_result(input string tag, input logic [5:0] e_rra, input logic e_rae,
                              input logic [3:0] e_cra, input logic e_cae, input logic e_rep);
    check({tag, " rra"}, 32'(rra), 32'(e_rra));
    check({tag, " rae"}, 32'(rae), 32'(e_rae));
    check({tag, " cra"}, 32'(cra), 32'(e_cra));
    check({tag, " cae"}, 32'(cae), 32'(e_cae));
    check({tag, " repairable"}, 32'(repairable), 32'(e_rep));
  endtask

  // end the run, capture the serial signature and compare with {cae,cra,rae,rra}
  task automatic finish_run(input string tag, input logic [5:0] e_rra, input logic e_rae,
                            input logic [3:0] e_cra, input logic e_cae);
    logic [SIG_W-1:0] got, exp;
    int nbits, wait_n;
    exp = {e_cae, e_cra, e_rae, e_rra};
    got = '0;
    nbits = 0;
    wait_n = 0;
    @(negedge clk); bist_done = 1'b1;
    @(negedge clk); bist_done = 1'b0;
    while (!sig_valid && wait_n < 40) begin
      @(negedge clk); wait_n++;
    end
    while (sig_valid && nbits < 40) begin
      if (nbits < SIG_W) got[nbits] = sig_bit;
      nbits++;
      @(negedge clk);
    end
    check({tag, " R8 signature bits"}, 32'(got), 32'(exp));
    check({tag, " R8 strobe length"}, 32'(nbits), 32'(SIG_W));
    check({tag, " R9 done"}, 32'(analysis_done), 32'd1);
    @(negedge clk);
    check({tag, " R9 done held, strobe low"}, {30'd0, analysis_done, sig_valid}, 32'd2);
  endtask

  task automatic t_reset();
    check("R1 reset rae", 32'(rae), 0);
    check("R1 reset cae", 32'(cae), 0);
    check("R1 reset repairable", 32'(repairable), 1);
    check("R9 reset done low", 32'(analysis_done), 0);
    check("R8 reset strobe low", 32'(sig_valid), 0);
  endtask

  task automatic t_idle_ignore();
    send_fail(6'd1, 4'd1);
    check_result("R7 idle fail", 6'd0, 1'b0, 4'd0, 1'b0, 1'b1);
  endtask

  task automatic t_clean();
    do_start();
    check_result("R1 after start", 6'd0, 1'b0, 4'd0, 1'b0, 1'b1);
    finish_run("R10 clean", 6'd0, 1'b0, 4'd0, 1'b0);
    check_result("R10 clean", 6'd0, 1'b0, 4'd0, 1'b0, 1'b1);
  endtask

  task automatic t_single();
    do_start();
    send_fail(6'd5, 4'd3);
    check("R6 no spare during collect", 32'(rae), 0);
    finish_run("R6 single", 6'd5, 1'b1, 4'd0, 1'b0);
    check_result("R6 single", 6'd5, 1'b1, 4'd0, 1'b0, 1'b1);
  endtask

  task automatic t_must_row();
    do_start();
    send_fail(6'd9, 4'd2);
    check("R3 first fail no spare", 32'(rae), 0);
    send_fail(6'd9, 4'd7);
    check_result("R3 must row", 6'd9, 1'b1, 4'd0, 1'b0, 1'b1);
    send_fail(6'd9, 4'd11);
    check_result("R2 covered row", 6'd9, 1'b1, 4'd0, 1'b0, 1'b1);
    finish_run("R3 must row", 6'd9, 1'b1, 4'd0, 1'b0);
  endtask

  task automatic t_must_col();
    do_start();
    send_fail(6'd3, 4'd6);
    send_fail(6'd12, 4'd6);
    check_result("R4 must col", 6'd0, 1'b0, 4'd6, 1'b1, 1'b1);
    send_fail(6'd40, 4'd6);
    check_result("R2 covered col", 6'd0, 1'b0, 4'd6, 1'b1, 1'b1);
    send_fail(6'd20, 4'd1);
    finish_run("R4 col then row", 6'd20, 1'b1, 4'd6, 1'b1);
    check_result("R6 leftover to row", 6'd20, 1'b1, 4'd6, 1'b1, 1'b1);
  endtask

  task automatic t_order();
    do_start();
    send_fail(6'd10, 4'd1);
    send_fail(6'd20, 4'd2);
    finish_run("R6 order", 6'd10, 1'b1, 4'd2, 1'b1);
    check_result("R6 order", 6'd10, 1'b1, 4'd2, 1'b1, 1'b1);
    send_fail(6'd33, 4'd3);
    check_result("R7 done fail", 6'd10, 1'b1, 4'd2, 1'b1, 1'b1);
  endtask

  task automatic t_too_many();
    do_start();
    send_fail(6'd1, 4'd1);
    send_fail(6'd2, 4'd2);
    check("R5 two fit", 32'(repairable), 1);
    send_fail(6'd3, 4'd3);
    check("R5 third unrepairable", 32'(repairable), 0);
    send_fail(6'd5, 4'd5);
    check("R5 sticky", 32'(repairable), 0);
    finish_run("R5 too many", 6'd1, 1'b1, 4'd2, 1'b1);
    check("R5 sticky after run", 32'(repairable), 0);
    do_start();
    check_result("R1 start clears", 6'd0, 1'b0, 4'd0, 1'b0, 1'b1);
    finish_run("R1 cleared run", 6'd0, 1'b0, 4'd0, 1'b0);
  endtask

  task automatic t_spares_used();
    do_start();
    send_fail(6'd9, 4'd2);
    send_fail(6'd9, 4'd7);
    send_fail(6'd3, 4'd6);
    send_fail(6'd12, 4'd6);
    check_result("R5 both spares", 6'd9, 1'b1, 4'd6, 1'b1, 1'b1);
    send_fail(6'd30, 4'd14);
    check("R5 no spare left", 32'(repairable), 0);
    finish_run("R5 spares used", 6'd9, 1'b1, 4'd6, 1'b1);
  endtask

  task automatic t_row_no_spare();
    do_start();
    send_fail(6'd9, 4'd2);
    send_fail(6'd9, 4'd7);
    send_fail(6'd4, 4'd1);
    send_fail(6'd4, 4'd8);
    check("R5 forced row, none free", 32'(repairable), 0);
    finish_run("R5 row no spare", 6'd9, 1'b1, 4'd1, 1'b1);
  endtask

  task automatic t_dup();
    do_start();
    send_fail(6'd4, 4'd4);
    send_fail(6'd4, 4'd4);
    check("R11 duplicate forces nothing", 32'(rae), 0);
    send_fail(6'd7, 4'd9);
    send_fail(6'd8, 4'd10);
    check("R11 duplicate took no slot", 32'(repairable), 0);
    finish_run("R11 dup", 6'd4, 1'b1, 4'd9, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_ignore();
    t_clean();
    t_single();
    t_must_row();
    t_must_col();
    t_order();
    t_too_many();
    t_spares_used();
    t_row_no_spare();
    t_dup();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule